// File: doc/BRIEF.md
# Instruction Timing Pulse Generator

This block paces one instruction cycle of a bit-serial machine. A fast oscillator clock is divided by a power-of-two ratio that can be selected. The result is a machine-clock enable. A decoded state counter then steps through a fixed sequence of numbered timing states. While the first `DATA_BITS` states are in progress it opens a shift gate, so the serial registers get exactly one shift enable per data bit. It also marks the first bit for carry initialisation. A parallel-load strobe for the operand register is issued before the first shift. An accumulator output-latch strobe is issued after the last shift.

A set/reset run latch decides when cycles happen. A run switch held high gives back-to-back cycles with no gap. A press of the step button runs exactly one whole cycle. Both inputs are synchronised to the oscillator clock. The step input is edge-detected, so how long the button is held does not matter. All outputs are single-clock-domain enables, so the clocked registers downstream run on the same oscillator clock.

Top module: `instr_timing_gen`

## Requirements
- R1: While reset is low, and whenever no cycle is running, `busy`, every `t_pulse` bit, `gate`, `shift_en`, `bit0`, `load_stb` and `acc_latch` are all low.
- R2: Every timing state lasts exactly 2^(div_sel+1) oscillator clocks, so a full cycle lasts (DATA_BITS+2) times that number.
- R3: While busy, exactly one bit of `t_pulse` is high. The states run T0, T1, … T(DATA_BITS+1) in increasing order, with T0 first. Bit k of `t_pulse` is high for the whole of state Tk.
- R4: `gate` is high throughout states T0..T(DATA_BITS-1). `shift_en` pulses for one clock at the last clock of each of those states, which gives exactly DATA_BITS pulses per cycle.
- R5: `bit0` is high only during T0, so it coincides with the first `shift_en` pulse and with no other.
- R6: `load_stb` pulses once per cycle, on the first clock of T0, before the first `shift_en`.
- R7: `acc_latch` pulses once per cycle, on the last clock of state T(DATA_BITS), after the last `shift_en`. After it, state T(DATA_BITS+1) follows with `gate` low.
- R8: One rising edge on `step_btn` while idle and `run_sw` is low runs exactly one cycle, however long the button is held.
- R9: A `step_btn` rising edge during a running cycle is ignored and does not cause an extra cycle.
- R10: While `run_sw` is high, cycles follow one another with no idle clock between them. When it goes low, the cycle in progress completes and the block then idles.
- R11: `div_sel` is sampled when each cycle begins. A change during a cycle does not alter that cycle's state length and applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | $clog2(DIV_STAGES) | Division select; each state lasts 2^(div_sel+1) clocks |
| run_sw | input | 1 | Asynchronous run switch; high for continuous cycles |
| step_btn | input | 1 | Asynchronous single-step button; each rising edge starts one cycle |
| busy | output | 1 | High while an instruction cycle is running |
| tick | output | 1 | Machine-clock enable, one clock at the end of each state |
| t_pulse | output | DATA_BITS+2 | One-hot timing states T0..T(DATA_BITS+1) |
| gate | output | 1 | Shift gate, high during the data-bit states |
| shift_en | output | 1 | Shift enable for the serial registers, DATA_BITS pulses per cycle |
| bit0 | output | 1 | First-bit marker, high during T0 |
| load_stb | output | 1 | Operand parallel-load strobe, first clock of T0 |
| acc_latch | output | 1 | Accumulator output-latch strobe, last clock of T(DATA_BITS) |

## Verification
The bench builds the block with its defaults: 14 divider stages, 8 data bits and a 2-stage synchroniser. That gives a ten-state cycle and a 4-bit `div_sel`. Only the select values 0 to 3 are driven, for state lengths of 2, 4, 8 and 16 clocks. This keeps single-step, held-button, mid-cycle press, continuous-run and mid-cycle ratio-change scenarios short. At the same time, the position of every strobe can be checked against the state length. The largest ratios, up to 2^14 clocks per state, are left to the parameterised arithmetic and are not driven.

// File: rtl/itg_pkg.sv
// Shared definitions for the instruction timing pulse generator.
// Assumes: nothing beyond standard SystemVerilog.
package itg_pkg;

    // Run-control latch state: idle between cycles, active during one.
    typedef enum logic {
        RC_IDLE   = 1'b0,
        RC_ACTIVE = 1'b1
    } runctl_e;

    // The synchroniser needs at least two flops to settle metastability.
    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/itg_sync.sv
// Input synchroniser with rising-edge detector.
// Brings an asynchronous level into the clk domain through STAGES flops.
// Flags a rising edge for one clock.
// Assumes: STAGES >= 2, and the input is held for at least STAGES+1 clocks per level.
module itg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // One flop per stage, each fed from the one before.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Pass the level down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Remember the previous settled level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] && !prev;

    // R8: a press yields a single edge flag, never two in a row.
    a_r8_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/itg_clkdiv.sv
// Machine-clock divider.
// Counts oscillator clocks during a running cycle and emits a one-clock
// tick every 2^(sel+1) clocks. The ratio is captured from div_sel whenever
// a cycle begins, so it stays fixed for the whole cycle.
// Assumes: cycle_begin is asserted at cycle start and at each state wrap.
module itg_clkdiv #(
    parameter int DIV_STAGES = 14,
    parameter int SEL_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             cycle_begin,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick,
    output logic             cnt_zero
);
    logic [DIV_STAGES-1:0] cnt;
    logic [DIV_STAGES-1:0] mask_q;
    logic [DIV_STAGES-1:0] mask_next;

    // Terminal-count mask: low (sel+1) bits set; larger selects saturate.
    genvar i;
    generate
        for (i = 0; i < DIV_STAGES; i++) begin : g_mask
            assign mask_next[i] = (int'(div_sel) >= i);
        end
    endgenerate

    // Hold the ratio fixed for the duration of one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)           mask_q <= DIV_STAGES'(1);
        else if (cycle_begin) mask_q <= mask_next;
    end

    // Count clocks within a state; restart on each tick and while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || tick) cnt <= '0;
        else                           cnt <= cnt + DIV_STAGES'(1);
    end

    assign tick     = active && (cnt == mask_q);
    assign cnt_zero = (cnt == '0);

    // R2: the shortest ratio is two, so ticks never touch.
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/itg_runctl.sv
// Run/step control latch.
// Set by a synchronised step edge or a held run level while idle.
// Cleared at the end of the last timing state unless the run level is
// still high. A step edge seen while active has no effect.
// Assumes: run_lvl and step_rise are already in the clk domain.
module itg_runctl
    import itg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_lvl,
    input  logic step_rise,
    input  logic tick,
    input  logic last_state,
    output logic active,
    output logic cycle_begin
);
    runctl_e st;
    logic    go;
    logic    cycle_end;

    assign go        = run_lvl || step_rise;
    assign cycle_end = (st == RC_ACTIVE) && tick && last_state;

    // New cycle starts from idle on a request, or chains at a wrap.
    assign cycle_begin = ((st == RC_IDLE) && go) || cycle_end;

    // Set/reset latch: set on a request when idle, reset at the end if not running.
    always_ff @(posedge clk) begin
        if (!rst_n)                          st <= RC_IDLE;
        else if ((st == RC_IDLE) && go)      st <= RC_ACTIVE;
        else if (cycle_end && !run_lvl)      st <= RC_IDLE;
    end

    assign active = (st == RC_ACTIVE);

    // R10: without the run level, the last tick ends the cycle.
    a_r10_stop_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && last_state && !run_lvl) |=> !active);

    // R9: a step edge mid-cycle cannot end or restart the cycle.
    a_r9_step_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step_rise && !(tick && last_state)) |=> active);

endmodule

// File: rtl/itg_seq.sv
// Timing state sequencer.
// Steps a state counter through T0..T(NUM_STATES-1) on each tick while
// active, decodes one-hot timing pulses, and derives the shift gate,
// shift enable, first-bit marker, load strobe and latch strobe.
// Assumes: NUM_STATES == BIT_STATES + 2; the counter rests at T0 when idle.
module itg_seq #(
    parameter int BIT_STATES = 8,
    parameter int NUM_STATES = BIT_STATES + 2,
    parameter int STATE_W    = $clog2(NUM_STATES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  active,
    input  logic                  tick,
    input  logic                  cnt_zero,
    output logic                  last_state,
    output logic [NUM_STATES-1:0] t_pulse,
    output logic                  gate,
    output logic                  shift_en,
    output logic                  bit0,
    output logic                  load_stb,
    output logic                  acc_latch
);
    localparam logic [STATE_W-1:0] LAST_ST  = STATE_W'(NUM_STATES - 1);
    localparam logic [STATE_W-1:0] LATCH_ST = STATE_W'(BIT_STATES);
    localparam logic [STATE_W-1:0] BITS_END = STATE_W'(BIT_STATES);

    logic [STATE_W-1:0] state;

    // Advance one state per tick, wrapping after the last; rest at T0 when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) state <= '0;
        else if (tick)         state <= (state == LAST_ST) ? '0 : state + STATE_W'(1);
    end

    // Decode one pulse line per state.
    genvar k;
    generate
        for (k = 0; k < NUM_STATES; k++) begin : g_pulse
            assign t_pulse[k] = active && (state == STATE_W'(k));
        end
    endgenerate

    assign last_state = (state == LAST_ST);
    assign gate       = active && (state < BITS_END);
    assign shift_en   = gate && tick;
    assign bit0       = active && (state == '0);
    assign load_stb   = bit0 && cnt_zero;
    assign acc_latch  = active && tick && (state == LATCH_ST);

    // R3: without a tick the state holds.
    a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> (state == $past(state)));

    // R3: a tick before the last state moves exactly one state on.
    a_r3_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick && !last_state) |=> (state == $past(state) + STATE_W'(1)));

    // R6: the load strobe never coincides with a shift.
    a_r6_load_not_shift: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> !shift_en);

    // R7: after the latch strobe comes the tail state with the gate closed.
    a_r7_latch_then_tail: assert property (@(posedge clk) disable iff (!rst_n)
        acc_latch |=> (t_pulse[NUM_STATES-1] && !gate));

endmodule

// File: rtl/instr_timing_gen.sv
// Instruction timing pulse generator, top level.
// Joins the input synchronisers, the run/step latch, the machine-clock
// divider and the state sequencer. Every output is a clock enable or
// level in the clk domain.
// Assumes: downstream registers run on clk and use shift_en, load_stb and
// acc_latch as enables.
module instr_timing_gen #(
    parameter int DIV_STAGES  = 14,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(DIV_STAGES),
    localparam int NUM_STATES = DATA_BITS + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      div_sel,
    input  logic                  run_sw,
    input  logic                  step_btn,
    output logic                  busy,
    output logic                  tick,
    output logic [NUM_STATES-1:0] t_pulse,
    output logic                  gate,
    output logic                  shift_en,
    output logic                  bit0,
    output logic                  load_stb,
    output logic                  acc_latch
);
    localparam int STATE_W = $clog2(NUM_STATES);

    logic run_lvl;
    logic run_rise_unused;
    logic step_lvl_unused;
    logic step_rise;
    logic active;
    logic cycle_begin;
    logic cnt_zero;
    logic last_state;

    // Bring the run switch into the clock domain.
    itg_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (run_sw),
        .level    (run_lvl),
        .rise     (run_rise_unused)
    );

    // Bring the step button into the clock domain and detect presses.
    itg_sync #(.STAGES(SYNC_STAGES)) u_step_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (step_btn),
        .level    (step_lvl_unused),
        .rise     (step_rise)
    );

    // Decide when cycles run.
    itg_runctl u_runctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_lvl     (run_lvl),
        .step_rise   (step_rise),
        .tick        (tick),
        .last_state  (last_state),
        .active      (active),
        .cycle_begin (cycle_begin)
    );

    // Derive the machine-clock enable.
    itg_clkdiv #(.DIV_STAGES(DIV_STAGES), .SEL_W(SEL_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .cycle_begin (cycle_begin),
        .div_sel     (div_sel),
        .tick        (tick),
        .cnt_zero    (cnt_zero)
    );

    // Sequence the timing states and strobes.
    itg_seq #(.BIT_STATES(DATA_BITS), .NUM_STATES(NUM_STATES), .STATE_W(STATE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .tick       (tick),
        .cnt_zero   (cnt_zero),
        .last_state (last_state),
        .t_pulse    (t_pulse),
        .gate       (gate),
        .shift_en   (shift_en),
        .bit0       (bit0),
        .load_stb   (load_stb),
        .acc_latch  (acc_latch)
    );

    assign busy = active;

    // R1: nothing is emitted outside a running cycle.
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (t_pulse == '0 && !gate && !shift_en && !load_stb && !acc_latch));

    // R4: a shift enable always falls inside the open gate.
    a_r4_shift_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> (gate && $onehot0(t_pulse)));

endmodule

// File: tb/tb_instr_timing_gen.sv
// Directed bench for the instruction timing pulse generator.
module tb_instr_timing_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NS         = 10;
    localparam int NB         = 8;
    localparam int WD_LIMIT   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    div_sel = 4'd0;
    logic          run_sw = 1'b0;
    logic          step_btn = 1'b0;
    logic          busy, tick, gate, shift_en, bit0, load_stb, acc_latch;
    logic [NS-1:0] t_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // Monitor state
    bit mon_on = 0;
    int pos, busy_len, n_load, n_shift, n_latch, n_b0s, n_b0bad, n_gate;
    int f_load, f_shift, l_shift, f_latch, n_t8, order_err, prev_idx, n_fall, idle_bad;
    bit prev_busy;

    instr_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .run_sw(run_sw),
        .step_btn(step_btn), .busy(busy), .tick(tick), .t_pulse(t_pulse),
        .gate(gate), .shift_en(shift_en), .bit0(bit0), .load_stb(load_stb),
        .acc_latch(acc_latch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    // Sample outputs on the falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            int idx;
            idx = -1;
            for (int k = 0; k < NS; k++) if (t_pulse[k]) idx = k;
            if (busy) begin
                busy_len++;
                if (load_stb) begin n_load++; if (f_load < 0) f_load = pos; end
                if (shift_en) begin
                    n_shift++; l_shift = pos;
                    if (f_shift < 0) f_shift = pos;
                    if (bit0) n_b0s++;
                end
                if (bit0 && !t_pulse[0]) n_b0bad++;
                if (gate) n_gate++;
                if (acc_latch) begin n_latch++; if (f_latch < 0) f_latch = pos; end
                if (t_pulse[8]) n_t8++;
                if ($countones(t_pulse) != 1) order_err++;
                else if (prev_idx < 0) begin if (idx != 0) order_err++; end
                else if (idx != prev_idx && idx != (prev_idx + 1) % NS) order_err++;
                prev_idx = idx;
                pos++;
            end else begin
                prev_idx = -1;
                if (t_pulse != '0 || gate || shift_en || bit0 || load_stb || acc_latch) idle_bad++;
            end
            if (prev_busy && !busy) n_fall++;
            prev_busy = busy;
        end
    end

    task automatic clear_mon();
        pos = 0; busy_len = 0; n_load = 0; n_shift = 0; n_latch = 0; n_b0s = 0;
        n_b0bad = 0; n_gate = 0; f_load = -1; f_shift = -1; l_shift = -1; f_latch = -1;
        n_t8 = 0; order_err = 0; prev_idx = -1; n_fall = 0; idle_bad = 0;
        prev_busy = busy; mon_on = 1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_end();
        while (n_fall < 1) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    // R1: outputs quiet in reset and after it with no request.
    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 pulses in reset", int'(t_pulse), 0);
        chk("R1 strobes in reset", int'({gate, shift_en, bit0, load_stb, acc_latch}), 0);
        rst_n = 1'b1;
        clear_mon();
        repeat (10) @(negedge clk);
        chk("R1 no spurious start", busy_len, 0);
        chk("R1 idle outputs", idle_bad, 0);
    endtask

    // R2-R8: one stepped cycle, full strobe placement.
    task automatic t_step(input int sel, input int hold);
        int r;
        r = 1 << (sel + 1);
        div_sel = 4'(sel);
        clear_mon();
        step_btn = 1'b1;
        repeat (hold) @(negedge clk);
        step_btn = 1'b0;
        wait_end();
        chk("R2/R8 cycle length", busy_len, NS * r);
        chk("R8 one cycle per press", n_load, 1);
        chk("R3 state order", order_err, 0);
        chk("R3 T8 width", n_t8, r);
        chk("R4 shift count", n_shift, NB);
        chk("R4 first shift pos", f_shift, r - 1);
        chk("R4 last shift pos", l_shift, NB * r - 1);
        chk("R4 gate width", n_gate, NB * r);
        chk("R5 bit0 on shifts", n_b0s, 1);
        chk("R5 bit0 outside T0", n_b0bad, 0);
        chk("R6 load pos", f_load, 0);
        chk("R7 latch count", n_latch, 1);
        chk("R7 latch pos", f_latch, (NB + 1) * r - 1);
        chk("R1 idle outputs", idle_bad, 0);
    endtask

    // R9: a second press mid-cycle adds nothing.
    task automatic t_busy_press();
        div_sel = 4'd2;
        clear_mon();
        step_btn = 1'b1;
        while (!busy) @(negedge clk);
        step_btn = 1'b0;
        repeat (10) @(negedge clk);
        step_btn = 1'b1;
        repeat (4) @(negedge clk);
        step_btn = 1'b0;
        wait_end();
        chk("R9 cycles after mid press", n_load, 1);
        chk("R9 cycle length", busy_len, NS * 8);
        chk("R9 idle after", int'(busy), 0);
    endtask

    // R10: continuous running, then a clean stop.
    task automatic t_run();
        div_sel = 4'd1;
        clear_mon();
        run_sw = 1'b1;
        repeat (100) @(negedge clk);
        run_sw = 1'b0;
        wait_end();
        chk("R10 several cycles", int'(n_load >= 2), 1);
        chk("R10 whole cycles only", busy_len, n_load * NS * 4);
        chk("R10 no gaps", n_fall, 1);
        chk("R10 shifts per cycle", n_shift, NB * n_load);
        chk("R10 latches per cycle", n_latch, n_load);
        chk("R10 state order", order_err, 0);
    endtask

    // R11: ratio change during a cycle waits for the next one.
    task automatic t_sel_change();
        div_sel = 4'd1;
        clear_mon();
        step_btn = 1'b1;
        while (!busy) @(negedge clk);
        repeat (3) @(negedge clk);
        div_sel = 4'd3;
        step_btn = 1'b0;
        wait_end();
        chk("R11 current cycle keeps ratio", busy_len, NS * 4);
        clear_mon();
        step_btn = 1'b1;
        repeat (4) @(negedge clk);
        step_btn = 1'b0;
        wait_end();
        chk("R11 next cycle uses new ratio", busy_len, NS * 16);
        chk("R11 shifts", n_shift, NB);
        chk("R11 first shift pos", f_shift, 15);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_step(0, 60);
        t_step(2, 4);
        t_busy_press();
        t_run();
        t_sel_change();
        summary();
        $finish;
    end

endmodule